// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio of 64·N + A and emits one pulse on `fp` for every full division cycle. It is the feedback divider of a frequency synthesizer. Its first stage is a prescaler that divides by 64 or 65. A 6-bit swallow counter holds the prescaler at 65 for the first A prescaler periods of a cycle. A 12-bit main counter counts N prescaler periods in total. So A periods last 65 input clocks and N − A periods last 64.

The ratio comes in on two parallel ports from a configuration latch outside the block. The counters take the ratio from those ports only at a cycle boundary, which is the last input clock of a cycle. They also take it on reset and on restart. A `restart` input puts the divider back at the start of a cycle. A power-save controller uses it on wake-up so that `fp` starts in a known phase with the reference divider. A ratio outside the legal range raises `cfg_err`. The divider then goes on counting with a defined substitute ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low at a rising edge, `fp` is 0 after that edge. At the same edge the ratio is taken from `n_cfg`/`a_cfg`, so counting starts at position 0 in the first cycle after reset is released.
- R2: With a legal ratio (5 ≤ N ≤ 4095, 0 ≤ A ≤ 63, N > A), `fp` is high once every 64·N + A input clocks. The divider behaves as A prescaler periods of 65 clocks followed by N − A periods of 64 clocks.
- R3: `fp` is exactly one input clock wide. It goes high in the first clock of each new division cycle, which is the clock after the last position of the previous cycle.
- R4: A change on `n_cfg` or `a_cfg` during a cycle has no effect on that cycle. The values present at the clock edge that ends the cycle set the length of the next cycle.
- R5: A high `restart` sampled at a rising edge puts the divider at position 0 in the next clock and loads the ratio from the ports. `fp` is 0 in that clock. The next `fp` comes 64·N + A clocks after that edge.
- R6: `cfg_err` is 1 for a cycle whose loaded ratio has N < 5 or N ≤ A, and is 0 otherwise. It changes only at a load edge: reset, restart or the end of a cycle.
- R7: With an illegal ratio the cycle length is 64·Ne + min(A, Ne), where Ne = max(N, 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock that is divided |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous phase restart to the start of a cycle |
| n_cfg | input | 12 | Main count N from the configuration latch |
| a_cfg | input | 6 | Swallow count A from the configuration latch |
| fp | output | 1 | One-clock pulse per completed division cycle |
| cfg_err | output | 1 | The ratio in use is outside the legal range |

## Verification
The only sign of a bad prescaler phase or a bad counter value is when `fp` arrives. A wrong swallow count shifts the pulse by a few clocks. A main counter that misses its terminal count shifts it by at least one 64-clock prescaler period. Either fault therefore appears at the first pulse after the fault, at most one division cycle later. The bench runs a behavioural model that tracks the position in the cycle and compares `fp` and `cfg_err` on every clock, so any shift shows at the exact clock where the pulse is missing or extra. A load taken at the wrong time shows up the same way after a ratio change in mid-cycle or a restart.

// File: rtl/psd_pkg.sv
// Shared widths and constants of the pulse-swallow divider.
package psd_pkg;
    // Prescaler base modulus (the alternate modulus is one higher).
    localparam int unsigned PRE_MOD = 64;
    // Width of the prescaler phase counter (must hold PRE_MOD).
    localparam int unsigned PRE_W   = $clog2(PRE_MOD + 1);
    // Width of the main and swallow counts.
    localparam int unsigned MAIN_W  = 12;
    localparam int unsigned SWAL_W  = 6;
    // Smallest legal main count.
    localparam int unsigned MAIN_MIN = 5;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler modelled as a synchronous counter.
// Counts 0..MOD-1, or 0..MOD when alt_sel is high, and raises wrap in its
// last state. Assumes alt_sel is stable within one prescaler period.
module psd_prescaler #(
    parameter int unsigned MOD = psd_pkg::PRE_MOD,
    parameter int unsigned W   = psd_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         alt_sel,
    output logic         wrap,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] LAST_BASE = W'(MOD - 1);
    localparam logic [W-1:0] LAST_ALT  = W'(MOD);

    // Terminal state depends on the modulus currently selected.
    always_comb begin
        wrap = (phase == (alt_sel ? LAST_ALT : LAST_BASE));
    end

    // Advance the phase, restarting at zero on wrap or load.
    always_ff @(posedge clk) begin
        if (!rst_n || load || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + W'(1);
        end
    end
endmodule

// File: rtl/psd_swallow.sv
// Swallow counter: holds the number of long (alternate-modulus) prescaler
// periods still to run in the current cycle. Loads on load, counts down
// once per prescaler wrap and stops at zero.
module psd_swallow #(
    parameter int unsigned W = psd_pkg::SWAL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         step,
    output logic         use_alt,
    output logic [W-1:0] left
);
    // Long periods remain while the count is nonzero.
    always_comb begin
        use_alt = (left != '0);
    end

    // Reload or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            left <= init;
        end else if (step && use_alt) begin
            left <= left - W'(1);
        end
    end
endmodule

// File: rtl/psd_main.sv
// Main counter: prescaler periods left in the current cycle, counting the
// current one. The cycle is in its last period when the count is 1 or less
// (a zero count ends after one period, so that an illegal N=0 still counts).
module psd_main #(
    parameter int unsigned W = psd_pkg::MAIN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         step,
    output logic         last,
    output logic [W-1:0] left
);
    // Last period of the cycle.
    always_comb begin
        last = (left <= W'(1));
    end

    // Reload or count down one prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            left <= init;
        end else if (step) begin
            left <= left - W'(1);
        end
    end
endmodule

// File: rtl/pulse_swallow_div.sv
// Pulse-swallow feedback divider with ratio 64*N + A.
// Chains the prescaler, the swallow counter and the main counter, reloads
// both counts from the ports at each cycle end, on reset and on restart,
// and emits a one-clock fp pulse at the start of each new cycle.
// Assumes n_cfg/a_cfg come from a latch that is stable near cycle ends.
module pulse_swallow_div #(
    parameter int unsigned N_W = psd_pkg::MAIN_W,
    parameter int unsigned A_W = psd_pkg::SWAL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [N_W-1:0] n_cfg,
    input  logic [A_W-1:0] a_cfg,
    output logic           fp,
    output logic           cfg_err
);
    localparam int unsigned P_W = psd_pkg::PRE_W;
    localparam logic [N_W-1:0] N_MIN = N_W'(psd_pkg::MAIN_MIN);

    logic           pre_wrap;
    logic [P_W-1:0] presc_cnt;
    logic           swal_alt;
    logic [A_W-1:0] swal_left;
    logic           main_last;
    logic [N_W-1:0] main_left;
    logic           cyc_end;
    logic           load;
    logic           bad_ratio;

    // A cycle ends on the prescaler wrap of the last main period.
    always_comb begin
        cyc_end   = pre_wrap && main_last;
        load      = restart || cyc_end;
        bad_ratio = (n_cfg < N_MIN) || (n_cfg <= {{(N_W-A_W){1'b0}}, a_cfg});
    end

    psd_prescaler #(.MOD(psd_pkg::PRE_MOD), .W(P_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .alt_sel (swal_alt),
        .wrap    (pre_wrap),
        .phase   (presc_cnt)
    );

    psd_swallow #(.W(A_W)) u_swal (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .init    (a_cfg),
        .step    (pre_wrap),
        .use_alt (swal_alt),
        .left    (swal_left)
    );

    psd_main #(.W(N_W)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .init  (n_cfg),
        .step  (pre_wrap),
        .last  (main_last),
        .left  (main_left)
    );

    // Output pulse in the first clock of each new cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fp <= 1'b0;
        end else begin
            fp <= cyc_end;
        end
    end

    // Flag the legality of the ratio loaded for the coming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cfg_err <= bad_ratio;
        end
    end
endmodule

// File: rtl/psd_checker.sv
// Assertion checker for pulse_swallow_div, attached by bind below.
module psd_checker #(
    parameter int unsigned N_W = psd_pkg::MAIN_W,
    parameter int unsigned P_W = psd_pkg::PRE_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           restart,
    input logic           fp,
    input logic           cfg_err,
    input logic [P_W-1:0] presc_cnt,
    input logic [N_W-1:0] main_left
);
    // R3
    fp_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fp);

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt <= P_W'(psd_pkg::PRE_MOD));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(restart) && !fp) |-> $stable(cfg_err));

    // R4
    main_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(restart) && !fp) |-> (main_left <= $past(main_left)));
endmodule

bind pulse_swallow_div psd_checker u_psd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .fp        (fp),
    .cfg_err   (cfg_err),
    .presc_cnt (presc_cnt),
    .main_left (main_left)
);

// File: tb/test_pulse_swallow_div.sv
// Bench: behavioural position model compared with fp and cfg_err each clock.
module test_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [11:0] n_cfg = 12'd5;
    logic [5:0]  a_cfg = 6'd0;
    logic        fp;
    logic        cfg_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    int  m_pos = 0;
    int  m_len = 320;
    bit  m_fp = 1'b0;
    bit  m_err = 1'b0;
    bit  prev_fp = 1'b0;
    bit  done = 1'b0;

    pulse_swallow_div i_pulse_swallow_div (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .n_cfg(n_cfg), .a_cfg(a_cfg), .fp(fp), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    function automatic int cyc_len(int n, int a);
        int ne;
        ne = (n < 1) ? 1 : n;
        return 64 * ne + ((a < ne) ? a : ne);
    endfunction

    function automatic bit bad(int n, int a);
        return (n < 5) || (n <= a);
    endfunction

    // Reference model: position within the division cycle.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || restart) begin
            m_len = cyc_len(n_cfg, a_cfg);
            m_err = bad(n_cfg, a_cfg);
            m_pos = 0;
            m_fp  = 1'b0;
        end else if (m_pos == m_len - 1) begin
            m_len = cyc_len(n_cfg, a_cfg);
            m_err = bad(n_cfg, a_cfg);
            m_pos = 0;
            m_fp  = 1'b1;
        end else begin
            m_pos++;
            m_fp = 1'b0;
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            checks++;
            if (fp !== m_fp) begin
                errors++;
                $display("FAIL %s fp actual=%0b expected=%0b at cycle %0d", tag, fp, m_fp, cycles);
            end
            checks++;
            if (cfg_err !== m_err) begin
                errors++;
                $display("FAIL %s cfg_err actual=%0b expected=%0b at cycle %0d", tag, cfg_err, m_err, cycles);
            end
            if (prev_fp) begin
                checks++;
                if (fp !== 1'b0) begin
                    errors++;
                    $display("FAIL R3 fp width actual=%0b expected=0", fp);
                end
            end
            prev_fp = (fp === 1'b1);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds fp low and loads the ratio
        tag = "R1";
        run(4);
        rst_n = 1'b1;
        // R2: N=5 A=0 gives 320, pulses every 320 clocks
        tag = "R2";
        run(3 * 320 + 10);
        // R4: change ratio mid-cycle, applies only at the next boundary
        tag = "R4";
        n_cfg = 12'd5; a_cfg = 6'd4;
        run(100);
        n_cfg = 12'd6; a_cfg = 6'd2;
        run(3 * 386 + 50);
        // R2: widest swallow range, N=64 A=63 gives 4159
        tag = "R2";
        n_cfg = 12'd64; a_cfg = 6'd63;
        run(2 * 4159 + 500);
        // R5: restart mid-cycle with N=7 A=3 (451)
        tag = "R5";
        n_cfg = 12'd7; a_cfg = 6'd3;
        run(200);
        restart = 1'b1;
        run(1);
        restart = 1'b0;
        run(3 * 451 + 20);
        // R6: N below minimum raises the flag, R7 length 192
        tag = "R6";
        n_cfg = 12'd3; a_cfg = 6'd0;
        run(3 * 451);
        tag = "R7";
        run(3 * 192);
        // R7: N <= A, N=10 A=20 gives 650
        n_cfg = 12'd10; a_cfg = 6'd20;
        run(3 * 650 + 200);
        // R7: N=0 A=5 gives 65
        n_cfg = 12'd0; a_cfg = 6'd5;
        run(5 * 65 + 700);
        // R6: back to legal clears the flag at the next boundary
        tag = "R6";
        n_cfg = 12'd20; a_cfg = 6'd19;
        run(3 * 1299 + 100);
        // R1: reset in mid-run
        tag = "R1";
        rst_n = 1'b0;
        run(3);
        checks++;
        if (fp !== 1'b0) begin
            errors++;
            $display("FAIL R1 fp in reset actual=%0b expected=0", fp);
        end
        rst_n = 1'b1;
        run(2 * 1299 + 10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule